// File: doc/BRIEF.md
# Fixed-Length Message Serial Link

This block is a full-duplex asynchronous serial link with no parity. Each character is one low start bit, eight data bits and one high stop bit, and every bit lasts a fixed number of clock cycles set by a parameter. A framing layer above the character level carries whole messages of fixed power-of-two length. On the outbound side, a wide parallel word is taken in one request and sent out byte by byte. On the inbound side, bytes are collected into a message, and only the most recent complete message is kept for the host.

The host starts a transmission by pulsing a request with the whole outbound word and watches a busy flag. Received messages show up on a parallel output with a valid flag, and the host clears that flag with a one-cycle acknowledge. Message lengths are fixed when the block is built. There is no parity, flow control, baud detection, or recovery after a partial message.

The transmit character engine has two states, TXC_IDLE and TXC_SHIFT. A start request moves it from TXC_IDLE to TXC_SHIFT. The end of the tenth bit period moves it back to TXC_IDLE.

The transmit framer has three states, FR_IDLE, FR_LOAD and FR_WAIT:
- An accepted request moves it from FR_IDLE to FR_LOAD.
- FR_LOAD always moves to FR_WAIT after one cycle.
- When a character completes, FR_WAIT moves back to FR_LOAD, or to FR_IDLE after the last byte.

The receive character engine has four states, RXC_IDLE, RXC_START, RXC_DATA and RXC_STOP:
- A low synchronised line moves it from RXC_IDLE to RXC_START.
- At 1.5 bit periods it moves from RXC_START to RXC_DATA.
- After the eighth data sample it moves from RXC_DATA to RXC_STOP.
- At 9.5 bit periods it moves from RXC_STOP back to RXC_IDLE.

The receive assembler has two states, AS_EMPTY and AS_HELD. A completed message moves it to AS_HELD. An acknowledge without a completion in the same cycle moves it to AS_EMPTY.

Top module: `msg_uart_link`

## Requirements
- R1: A character on `txd` is a low start bit, then eight data bits least significant bit first, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles, and `txd` is high whenever no message is being sent.
- R2: An outbound message is 2^TX_LOG2_BYTES bytes. Byte 0 is `send_data[7:0]` and is sent first, followed by the higher bytes in order. There is one extra idle-high clock between consecutive characters.
- R3: `send_req` is accepted only while `send_busy` is low. A request made while busy is ignored: nothing extra is sent, during the message or after it.
- R4: `send_busy` rises one cycle after an accepted request. It stays high for exactly 2^TX_LOG2_BYTES*(10*CLKS_PER_BIT+1) cycles and falls as the last stop bit ends.
- R5: `rxd` passes through a two-flop synchroniser. The first low level seen while idle is taken as a start edge, and data bits are sampled 1.5, 2.5, and so on up to 8.5 bit periods after it.
- R6: The receiver re-arms for a new start bit only 9.5 bit periods after the start edge. A byte whose top bit is 0 therefore produces no extra byte, so two received strobes are always at least nine bit periods apart.
- R7: An inbound message is 2^RX_LOG2_BYTES bytes. The first byte received lands in `rx_msg[7:0]`, and later bytes fill higher bytes in order. `rx_valid` rises the cycle after the last byte completes.
- R8: A one-cycle `rx_ack` clears `rx_valid` on the next cycle and leaves `rx_msg` unchanged. If a message completes in the same cycle as the acknowledge, `rx_valid` stays set.
- R9: A message that completes while the previous one is unread replaces it in `rx_msg`, and `rx_valid` stays high.
- R10: After reset, `txd` is high, `send_busy` and `rx_valid` are low, and `rx_msg` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_req | input | 1 | Request to send the word on `send_data` |
| send_data | input | 8*2^TX_LOG2_BYTES | Outbound message, byte 0 in the low bits |
| send_busy | output | 1 | Outbound message in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_msg | output | 8*2^RX_LOG2_BYTES | Most recent complete inbound message |
| rx_valid | output | 1 | `rx_msg` holds an unread message |
| rx_ack | input | 1 | Clears `rx_valid` |

## Verification
A wrong receive counter or an early re-arm does not stay hidden inside the block. It misaligns every later message, because a spurious or missing byte shifts the byte order in `rx_msg` from the next completion onward. Sending bytes with a zero top bit, then a byte with a one top bit, exposes this within one message. On the transmit side, a framer index or bit counter that is off by one shows up within a single character: it gives a wrong decoded byte or a busy length that differs from the exact cycle count. An accepted request that should have been ignored shows up as extra characters on `txd` after the busy flag falls.

// File: rtl/msg_uart_pkg.sv
package msg_uart_pkg;

    typedef enum logic [0:0] {
        TXC_IDLE,
        TXC_SHIFT
    } txc_state_t;

    typedef enum logic [1:0] {
        RXC_IDLE,
        RXC_START,
        RXC_DATA,
        RXC_STOP
    } rxc_state_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LOAD,
        FR_WAIT
    } fr_state_t;

    typedef enum logic [0:0] {
        AS_EMPTY,
        AS_HELD
    } as_state_t;

    localparam int CHAR_BITS = 10;

endpackage

// File: rtl/msg_uart_tx_char.sv
module msg_uart_tx_char
    import msg_uart_pkg::*;
#(
    parameter int C = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    output logic       txd,
    output logic       done
);
    localparam int CW = (C > 1) ? $clog2(C) : 1;
    localparam logic [CW-1:0] CLAST = CW'(C - 1);
    localparam logic [3:0] BLAST = 4'(CHAR_BITS - 1);

    txc_state_t state, nxt;
    logic [CHAR_BITS-1:0] shreg;
    logic [CW-1:0] cyc;
    logic [3:0] bitn;
    logic bit_end;

    assign bit_end = (cyc == CLAST);
    assign txd = shreg[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        done = 1'b0;
        unique case (state)
            TXC_IDLE:  if (start) nxt = TXC_SHIFT;
            TXC_SHIFT: if (bit_end && bitn == BLAST) begin
                nxt  = TXC_IDLE;
                done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            cyc   <= '0;
            bitn  <= '0;
        end else if (state == TXC_IDLE) begin
            if (start) begin
                shreg <= {1'b1, din, 1'b0};
                cyc   <= '0;
                bitn  <= '0;
            end
        end else if (bit_end) begin
            cyc   <= '0;
            bitn  <= bitn + 4'd1;
            shreg <= {1'b1, shreg[CHAR_BITS-1:1]};
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/msg_uart_rx_char.sv
module msg_uart_rx_char
    import msg_uart_pkg::*;
#(
    parameter int C = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic [7:0] dout,
    output logic       strobe
);
    localparam int FIRST = C + C / 2 - 1;
    localparam int NW = $clog2(FIRST + 1);
    localparam logic [NW-1:0] FIRST_LIM = NW'(FIRST);
    localparam logic [NW-1:0] CLAST = NW'(C - 1);

    rxc_state_t state, nxt;
    logic [1:0] sync_q;
    logic rx_s;
    logic [NW-1:0] cnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic first_hit, period_hit, take;

    assign rx_s = sync_q[1];
    assign first_hit = (state == RXC_START) && (cnt == FIRST_LIM);
    assign period_hit = (state != RXC_START) && (cnt == CLAST);
    assign take = first_hit || (state == RXC_DATA && period_hit);
    assign dout = shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RXC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        strobe = 1'b0;
        unique case (state)
            RXC_IDLE:  if (!rx_s) nxt = RXC_START;
            RXC_START: if (first_hit) nxt = RXC_DATA;
            RXC_DATA:  if (period_hit && bitn == 3'd7) nxt = RXC_STOP;
            RXC_STOP:  if (period_hit) begin
                nxt    = RXC_IDLE;
                strobe = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            if (state == RXC_IDLE || first_hit || period_hit) cnt <= '0;
            else cnt <= cnt + 1'b1;
            if (take) shreg <= {rx_s, shreg[7:1]};
            if (state == RXC_IDLE) bitn <= '0;
            else if (take) bitn <= bitn + 3'd1;
        end
    end
endmodule

// File: rtl/msg_uart_tx_framer.sv
module msg_uart_tx_framer
    import msg_uart_pkg::*;
#(
    parameter int T = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               send_req,
    input  logic [8*(1<<T)-1:0] send_data,
    output logic               busy,
    output logic               char_start,
    output logic [7:0]         char_byte,
    input  logic               char_done
);
    localparam int NB = 1 << T;
    localparam int W = 8 * NB;
    localparam int IW = (T > 0) ? T : 1;
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    fr_state_t state, nxt;
    logic [W-1:0] msg;
    logic [IW-1:0] idx;

    assign char_byte = msg[{idx, 3'b000} +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        char_start = 1'b0;
        busy       = 1'b1;
        unique case (state)
            FR_IDLE: begin
                busy = 1'b0;
                if (send_req) nxt = FR_LOAD;
            end
            FR_LOAD: begin
                char_start = 1'b1;
                nxt        = FR_WAIT;
            end
            FR_WAIT: if (char_done) nxt = (idx == LAST) ? FR_IDLE : FR_LOAD;
            default: nxt = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg <= '0;
            idx <= '0;
        end else if (state == FR_IDLE && send_req) begin
            msg <= send_data;
            idx <= '0;
        end else if (state == FR_WAIT && char_done && idx != LAST) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/msg_uart_rx_assembler.sv
module msg_uart_rx_assembler
    import msg_uart_pkg::*;
#(
    parameter int R = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         byte_in,
    input  logic               byte_stb,
    input  logic               rx_ack,
    output logic [8*(1<<R)-1:0] rx_msg,
    output logic               rx_valid
);
    localparam int NB = 1 << R;
    localparam int W = 8 * NB;
    localparam int IW = (R > 0) ? R : 1;
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    as_state_t state, nxt;
    logic [W-1:0] sh, sh_next;
    logic [IW-1:0] cnt;
    logic msg_done;

    generate
        if (NB == 1) begin : g_single
            assign sh_next = byte_in;
        end else begin : g_multi
            assign sh_next = {byte_in, sh[W-1:8]};
        end
    endgenerate

    assign msg_done = byte_stb && (cnt == LAST);
    assign rx_valid = (state == AS_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AS_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            AS_EMPTY: if (msg_done) nxt = AS_HELD;
            AS_HELD:  if (!msg_done && rx_ack) nxt = AS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            rx_msg <= '0;
        end else if (byte_stb) begin
            sh  <= sh_next;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (msg_done) rx_msg <= sh_next;
        end
    end
endmodule

// File: rtl/msg_uart_link.sv
module msg_uart_link #(
    parameter int CLKS_PER_BIT  = 16,
    parameter int TX_LOG2_BYTES = 1,
    parameter int RX_LOG2_BYTES = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            send_req,
    input  logic [8*(1<<TX_LOG2_BYTES)-1:0] send_data,
    output logic                            send_busy,
    output logic                            txd,
    input  logic                            rxd,
    output logic [8*(1<<RX_LOG2_BYTES)-1:0] rx_msg,
    output logic                            rx_valid,
    input  logic                            rx_ack
);
    logic       tx_char_start, tx_char_done;
    logic [7:0] tx_char_byte;
    logic [7:0] rx_byte;
    logic       rx_byte_stb;

    msg_uart_tx_framer #(.T(TX_LOG2_BYTES)) u_framer (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .busy(send_busy), .char_start(tx_char_start), .char_byte(tx_char_byte),
        .char_done(tx_char_done)
    );

    msg_uart_tx_char #(.C(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_char_start), .din(tx_char_byte),
        .txd(txd), .done(tx_char_done)
    );

    msg_uart_rx_char #(.C(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .dout(rx_byte), .strobe(rx_byte_stb)
    );

    msg_uart_rx_assembler #(.R(RX_LOG2_BYTES)) u_asm (
        .clk(clk), .rst_n(rst_n), .byte_in(rx_byte), .byte_stb(rx_byte_stb),
        .rx_ack(rx_ack), .rx_msg(rx_msg), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/msg_uart_link_chk.sv
module msg_uart_link_chk #(
    parameter int C = 16
) (
    input logic clk,
    input logic rst_n,
    input logic send_req,
    input logic send_busy,
    input logic txd,
    input logic rx_valid,
    input logic rx_ack,
    input logic byte_stb
);
    localparam int LIM = 10 * C;
    localparam int GW = $clog2(LIM + 1) + 1;
    localparam logic [GW-1:0] GLIM = GW'(LIM);
    localparam logic [GW-1:0] GMIN = GW'(9 * C);

    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap <= GLIM;
        else if (byte_stb) gap <= GW'(1);
        else if (gap < GLIM) gap <= gap + 1'b1;
    end

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !send_busy |-> txd);                                   // R1
    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_busy) |-> $past(send_req));                 // R3
    AST_VALID_DROP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> $past(rx_ack));                    // R8
    AST_MSG_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(byte_stb));                  // R7
    AST_REARM_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> gap >= GMIN);                             // R6
endmodule

bind msg_uart_link msg_uart_link_chk #(.C(CLKS_PER_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_busy(send_busy),
    .txd(txd), .rx_valid(rx_valid), .rx_ack(rx_ack), .byte_stb(rx_byte_stb)
);

// File: tb/msg_uart_link_bench.sv
module msg_uart_link_bench;
    localparam int C = 16;
    localparam int T = 1;
    localparam int R = 1;
    localparam int TW = 8 * (1 << T);
    localparam int RW = 8 * (1 << R);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_req = 1'b0;
    logic [TW-1:0] send_data = '0;
    logic send_busy, txd;
    logic rx_drv = 1'b1;
    logic loop_en = 1'b0;
    logic rxd;
    logic [RW-1:0] rx_msg;
    logic rx_valid;
    logic rx_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int busy_cycles = 0;
    int mon_bytes = 0;
    logic [7:0] exp_q[$];

    assign rxd = loop_en ? txd : rx_drv;

    always #2.5 clk = ~clk;

    msg_uart_link #(.CLKS_PER_BIT(C), .TX_LOG2_BYTES(T), .RX_LOG2_BYTES(R)) u_msg_uart_link (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .send_busy(send_busy), .txd(txd), .rxd(rxd), .rx_msg(rx_msg),
        .rx_valid(rx_valid), .rx_ack(rx_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // busy length counter, sampled away from the active edge
    always @(negedge clk) if (send_busy) busy_cycles++;

    // scoreboard monitor: decodes txd and compares with the expected queue
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                repeat (C / 2 - 1) @(negedge clk);
                check(txd == 1'b0, "R1 start bit low", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (C) @(negedge clk);
                    b[i] = txd;
                end
                repeat (C) @(negedge clk);
                check(txd == 1'b1, "R1 stop bit high", txd, 1);
                mon_bytes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected byte on txd", b, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(b == e, "R1/R2 transmitted byte", b, e);
                end
            end
        end
    end

    task automatic send_msg(input logic [TW-1:0] d);
        for (int i = 0; i < (1 << T); i++) exp_q.push_back(d[8*i +: 8]);
        @(negedge clk);
        send_data = d;
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
    endtask

    task automatic drive_byte(input logic [7:0] b);
        rx_drv = 1'b0;
        repeat (C) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (C) @(negedge clk);
        end
        rx_drv = 1'b1;
        repeat (C) @(negedge clk);
    endtask

    task automatic drive_msg(input logic [RW-1:0] m);
        for (int i = 0; i < (1 << R); i++) drive_byte(m[8*i +: 8]);
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(txd == 1'b1, "R10 txd idle after reset", txd, 1);
        check(send_busy == 1'b0, "R10 busy low after reset", send_busy, 0);
        check(rx_valid == 1'b0, "R10 rx_valid low after reset", rx_valid, 0);
        check(rx_msg == '0, "R10 rx_msg zero after reset", rx_msg, 0);

        // R2 R4: message transmit and exact busy length; R3 ignored request
        busy_cycles = 0;
        send_msg(16'hA55A);
        repeat (50) @(negedge clk);
        send_data = 16'hFFFF;
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        while (send_busy) @(negedge clk);
        check(busy_cycles == (1 << T) * (10 * C + 1), "R4 busy length",
              busy_cycles, (1 << T) * (10 * C + 1));
        check(txd == 1'b1, "R4 line high as busy falls", txd, 1);
        repeat (12 * C) @(negedge clk);
        check(mon_bytes == 2, "R3 ignored request sent nothing", mon_bytes, 2);
        check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

        // second message with different pattern
        send_msg(16'h0F81);
        @(negedge clk);
        while (send_busy) @(negedge clk);
        repeat (C) @(negedge clk);
        check(mon_bytes == 4, "R2 second message byte count", mon_bytes, 4);

        // R5 R7: inbound message, byte order
        drive_msg(16'h3412);
        check(rx_valid == 1'b1, "R7 valid after message", rx_valid, 1);
        check(rx_msg == 16'h3412, "R7 byte order", rx_msg, 16'h3412);

        // R8 ack clears valid, keeps data
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        check(rx_valid == 1'b0, "R8 ack clears valid", rx_valid, 0);
        check(rx_msg == 16'h3412, "R8 data kept after ack", rx_msg, 16'h3412);

        // R6: zero top bits must not create extra bytes (alignment kept)
        drive_msg(16'h0000);
        check(rx_msg == 16'h0000, "R6 zero bytes", rx_msg, 0);
        drive_msg(16'h0180);
        check(rx_msg == 16'h0180, "R6 alignment after zero MSB", rx_msg, 16'h0180);

        // R9 overwrite while unread
        check(rx_valid == 1'b1, "R9 still unread", rx_valid, 1);
        drive_msg(16'hBEEF);
        check(rx_msg == 16'hBEEF, "R9 overwrite unread", rx_msg, 16'hBEEF);
        check(rx_valid == 1'b1, "R9 valid stays high", rx_valid, 1);

        // R5 loopback through both paths
        loop_en = 1'b1;
        send_msg(16'h1357);
        @(negedge clk);
        while (send_busy) @(negedge clk);
        repeat (C) @(negedge clk);
        check(rx_msg == 16'h1357, "R5 loopback message", rx_msg, 16'h1357);
        check(exp_q.size() == 0, "R2 loopback bytes seen", exp_q.size(), 0);

        finish_run();
    end
endmodule